// File: doc/BRIEF.md
# Lockable Prescaled Watchdog Timer

This block is a retriggerable one-shot watchdog for a small microcontroller. It runs from the crystal clock. A power-of-two prescaler steps a down-counter, so a narrow counter still gives long timeout periods. Software selects one of seven periods, each double the one before, or switches the watchdog off. It also chooses whether the count continues in halt mode and whether the stop instruction is honoured. These choices can be written only while the first instruction after reset executes. After that the configuration is frozen until the next reset.

The core pulses a refresh strobe to restart the period. If the counter runs out, the block raises a one-cycle timeout event, presents the fixed recovery vector 0x0020 and sets a sticky timeout flag. Together with a sticky stop-recovery flag, this lets software tell a pin reset from a watchdog timeout and from a return out of stop. Only the external reset pin clears both flags. An internal soft reset re-initialises everything else and leaves the flags alone.

Top module: `lock_wdog`

## Requirements
- R1: With P = 2^PRE_LOG2 and select code c in 1..7, the period is P * 2^(BASE_LOG2+c-1) clocks. The count starts at a reload edge, and `timeoutEvt` is high in the cycle after the clock edge that ends the period. With the defaults this is 64 * 1024 * 2^(c-1) clocks, from 65,536 to 4,194,304.
- R2: Select code 000 disables the watchdog, and `timeoutEvt` never rises.
- R3: After `pinRstN` is released, the select code is 111 and the watchdog runs with the longest period. Halt counting is on and the stop instruction is not honoured.
- R4: `cfgWrData` is laid out as bits [4:2] select code, bit 1 halt-count enable and bit 0 stop enable. A write with `cfgWr` is accepted only from reset release up to and including the cycle in which `instrDone` is high. An accepted write reloads the counter. Any later write is ignored.
- R5: `refresh` reloads the prescaler and the counter, so a full period starts from that edge.
- R6: If `refresh` lands on the edge where the counter expires, the timeout still fires. The next period starts from that edge.
- R7: `mode` 01 is halt. In halt the count continues when the halt-count enable is 1 and freezes, keeping its value, when it is 0.
- R8: `mode` 10 or 11 is stop, and the count freezes there. `mode` 00 is run, and the count resumes from where it stopped.
- R9: A timeout gives a one-cycle `timeoutEvt` pulse, sets `wdtFlag` and reloads the counter. `vecAddr` reads 0x0020.
- R10: `wdtFlag` stays set until `wdtFlagClr`. A timeout on the same edge as a clear wins.
- R11: `stopExec` sets `stopFlag` only when the stop enable is 1, and `stopFlagClr` clears it.
- R12: `pinRstN` low clears both flags. `softRst` restores the default configuration, reopens the write window and reloads the counter, and it leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| pinRstN | input | 1 | External reset pin, active low, asynchronous |
| softRst | input | 1 | Internal synchronous reset that keeps the flags |
| mode | input | 2 | 00 run, 01 halt, 10/11 stop |
| refresh | input | 1 | Watchdog service strobe |
| instrDone | input | 1 | Marks the end of the first instruction after reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgWrData | input | 5 | Select code, halt enable, stop enable |
| stopExec | input | 1 | Stop instruction executed |
| wdtFlagClr | input | 1 | Clears the timeout flag |
| stopFlagClr | input | 1 | Clears the stop-recovery flag |
| timeoutEvt | output | 1 | One-cycle timeout and vector request |
| vecAddr | output | 16 | Recovery vector address |
| wdtFlag | output | 1 | Sticky timeout cause |
| stopFlag | output | 1 | Sticky stop-recovery cause |

## Verification
The block has two same-cycle collisions. A refresh can land on the expiry edge, and a flag clear can land on the edge that sets the flag. The bench first measures a timeout edge. It then counts exactly one period forward and drives `refresh` and `wdtFlagClr` for that single edge. The run passes if the event still fires, the flag still reads set, and the following timeout comes one full period after the collision edge rather than after some shortened or lengthened interval.

// File: rtl/lwdt_pkg.sv
`timescale 1ns/1ps
package lwdt_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_HALT  = 2'b01,
    MODE_STOP  = 2'b10,
    MODE_STOPX = 2'b11
  } mode_e;

  typedef struct packed {
    logic reload;
    logic countEn;
  } dpStrb_t;

  typedef struct packed {
    logic [2:0] sel;
    logic       haltEn;
    logic       stopEn;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{sel: 3'b111, haltEn: 1'b1, stopEn: 1'b0};
endpackage

// File: rtl/lwdt_datapath.sv
`timescale 1ns/1ps
module lwdt_datapath
  import lwdt_pkg::*;
#(
  parameter int PRE_LOG2  = 6,
  parameter int BASE_LOG2 = 10
) (
  input  logic       clk,
  input  logic       pinRstN,
  input  dpStrb_t    strb,
  input  logic [2:0] loadSel,
  output logic       expire
);
  localparam int CNT_W = BASE_LOG2 + 6;

  logic [PRE_LOG2-1:0] pre;
  logic [CNT_W-1:0]    count;
  logic                tick;

  function automatic logic [CNT_W-1:0] loadValue(input logic [2:0] sel);
    logic [CNT_W:0] full;
    int shamt;
    shamt = (sel == 3'd0) ? BASE_LOG2 : BASE_LOG2 + int'(sel) - 1;
    full  = (CNT_W+1)'(1) << shamt;
    return CNT_W'(full - (CNT_W+1)'(1));
  endfunction

  assign tick   = strb.countEn && (pre == '1);
  assign expire = tick && (count == '0);

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN) begin
      pre   <= '0;
      count <= loadValue(CFG_DEFAULT.sel);
    end else if (strb.reload) begin
      pre   <= '0;
      count <= loadValue(loadSel);
    end else if (strb.countEn) begin
      pre <= pre + 1'b1;
      if (tick) count <= count - 1'b1;
    end
  end

  // Frozen count in stop, or in halt with halt counting off
  p_frozen_r8: assert property (@(posedge clk) disable iff (!pinRstN)
    (!strb.countEn && !strb.reload) |=> ($stable(count) && $stable(pre)));

  // The counter moves by at most one step per prescaler wrap
  p_single_step_r1: assert property (@(posedge clk) disable iff (!pinRstN)
    (!strb.reload && !tick) |=> $stable(count));
endmodule

// File: rtl/lwdt_ctrl.sv
`timescale 1ns/1ps
module lwdt_ctrl
  import lwdt_pkg::*;
(
  input  logic       clk,
  input  logic       pinRstN,
  input  logic       softRst,
  input  logic [1:0] mode,
  input  logic       refresh,
  input  logic       instrDone,
  input  logic       cfgWr,
  input  logic [4:0] cfgWrData,
  input  logic       stopExec,
  input  logic       wdtFlagClr,
  input  logic       stopFlagClr,
  input  logic       expire,
  output dpStrb_t    strb,
  output logic [2:0] loadSel,
  output logic       timeoutEvt,
  output logic       wdtFlag,
  output logic       stopFlag
);
  cfg_t  cfg, cfgNext;
  logic  winOpen;
  logic  cfgAccept;
  logic  enabled;
  mode_e curMode;

  assign curMode   = mode_e'(mode);
  assign cfgAccept = cfgWr && winOpen && !softRst;
  assign enabled   = (cfg.sel != 3'b000);

  always_comb begin
    cfgNext = cfg;
    if (softRst)        cfgNext = CFG_DEFAULT;
    else if (cfgAccept) cfgNext = cfg_t'(cfgWrData);
  end

  assign loadSel = cfgNext.sel;

  always_comb begin
    strb.countEn = 1'b0;
    if (enabled) begin
      unique case (curMode)
        MODE_RUN:  strb.countEn = 1'b1;
        MODE_HALT: strb.countEn = cfg.haltEn;
        default:   strb.countEn = 1'b0;
      endcase
    end
    strb.reload = refresh || expire || cfgAccept || softRst;
  end

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN) begin
      cfg     <= CFG_DEFAULT;
      winOpen <= 1'b1;
    end else begin
      cfg <= cfgNext;
      if (softRst)        winOpen <= 1'b1;
      else if (instrDone) winOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN) begin
      timeoutEvt <= 1'b0;
      wdtFlag    <= 1'b0;
      stopFlag   <= 1'b0;
    end else begin
      timeoutEvt <= expire;
      if (expire)          wdtFlag <= 1'b1;
      else if (wdtFlagClr) wdtFlag <= 1'b0;
      if (stopExec && cfg.stopEn) stopFlag <= 1'b1;
      else if (stopFlagClr)       stopFlag <= 1'b0;
    end
  end

  p_evt_pulse_r9: assert property (@(posedge clk) disable iff (!pinRstN)
    timeoutEvt |=> !timeoutEvt);

  p_evt_flag_r9: assert property (@(posedge clk) disable iff (!pinRstN)
    timeoutEvt |-> wdtFlag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!pinRstN)
    (wdtFlag && !wdtFlagClr) |=> wdtFlag);

  p_cfg_locked_r4: assert property (@(posedge clk) disable iff (!pinRstN)
    (!winOpen && !softRst) |=> $stable(cfg));

  p_off_no_expire_r2: assert property (@(posedge clk) disable iff (!pinRstN)
    (cfg.sel == 3'b000) |-> !expire);
endmodule

// File: rtl/lock_wdog.sv
`timescale 1ns/1ps
module lock_wdog
  import lwdt_pkg::*;
#(
  parameter int          PRE_LOG2  = 6,
  parameter int          BASE_LOG2 = 10,
  parameter logic [15:0] VEC_ADDR  = 16'h0020
) (
  input  logic        clk,
  input  logic        pinRstN,
  input  logic        softRst,
  input  logic [1:0]  mode,
  input  logic        refresh,
  input  logic        instrDone,
  input  logic        cfgWr,
  input  logic [4:0]  cfgWrData,
  input  logic        stopExec,
  input  logic        wdtFlagClr,
  input  logic        stopFlagClr,
  output logic        timeoutEvt,
  output logic [15:0] vecAddr,
  output logic        wdtFlag,
  output logic        stopFlag
);
  dpStrb_t    strb;
  logic [2:0] loadSel;
  logic       expire;

  assign vecAddr = VEC_ADDR;

  lwdt_ctrl u_ctrl (
    .clk(clk), .pinRstN(pinRstN), .softRst(softRst), .mode(mode),
    .refresh(refresh), .instrDone(instrDone), .cfgWr(cfgWr),
    .cfgWrData(cfgWrData), .stopExec(stopExec), .wdtFlagClr(wdtFlagClr),
    .stopFlagClr(stopFlagClr), .expire(expire), .strb(strb),
    .loadSel(loadSel), .timeoutEvt(timeoutEvt), .wdtFlag(wdtFlag),
    .stopFlag(stopFlag)
  );

  lwdt_datapath #(.PRE_LOG2(PRE_LOG2), .BASE_LOG2(BASE_LOG2)) u_dp (
    .clk(clk), .pinRstN(pinRstN), .strb(strb), .loadSel(loadSel),
    .expire(expire)
  );
endmodule

// File: tb/lock_wdog_tb.sv
`timescale 1ns/1ps
module lock_wdog_tb;
  localparam int PRE_LOG2  = 2;
  localparam int BASE_LOG2 = 3;

  logic        clk = 1'b0;
  logic        pinRstN = 1'b0;
  logic        softRst = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        refresh = 1'b0;
  logic        instrDone = 1'b0;
  logic        cfgWr = 1'b0;
  logic [4:0]  cfgWrData = '0;
  logic        stopExec = 1'b0;
  logic        wdtFlagClr = 1'b0;
  logic        stopFlagClr = 1'b0;
  logic        timeoutEvt;
  logic [15:0] vecAddr;
  logic        wdtFlag;
  logic        stopFlag;

  int nChk = 0;
  int nBad = 0;

  lock_wdog #(.PRE_LOG2(PRE_LOG2), .BASE_LOG2(BASE_LOG2)) u_dut (
    .clk(clk), .pinRstN(pinRstN), .softRst(softRst), .mode(mode),
    .refresh(refresh), .instrDone(instrDone), .cfgWr(cfgWr),
    .cfgWrData(cfgWrData), .stopExec(stopExec), .wdtFlagClr(wdtFlagClr),
    .stopFlagClr(stopFlagClr), .timeoutEvt(timeoutEvt), .vecAddr(vecAddr),
    .wdtFlag(wdtFlag), .stopFlag(stopFlag)
  );

  always #10 clk = ~clk;

  // code, mode, haltEn, fires
  localparam logic [6:0] VECS [9] = '{
    {3'd1, 2'b00, 1'b1, 1'b1},
    {3'd2, 2'b00, 1'b1, 1'b1},
    {3'd4, 2'b00, 1'b0, 1'b1},
    {3'd5, 2'b00, 1'b1, 1'b1},
    {3'd7, 2'b00, 1'b0, 1'b1},
    {3'd3, 2'b01, 1'b1, 1'b1},
    {3'd2, 2'b01, 1'b0, 1'b0},
    {3'd0, 2'b00, 1'b1, 1'b0},
    {3'd6, 2'b01, 1'b1, 1'b1}
  };

  function automatic int periodOf(input int code);
    return (1 << PRE_LOG2) * (1 << (BASE_LOG2 + code - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pinReset();
    @(negedge clk);
    pinRstN = 1'b0; softRst = 0; refresh = 0; instrDone = 0; cfgWr = 0;
    stopExec = 0; wdtFlagClr = 0; stopFlagClr = 0; mode = 2'b00;
    @(negedge clk);
    @(negedge clk);
    pinRstN = 1'b1;
  endtask

  task automatic pulseRefresh();
    refresh = 1'b1;
    @(posedge clk);
    @(negedge clk);
    refresh = 1'b0;
  endtask

  task automatic writeCfg(input logic [4:0] d, input logic done);
    cfgWr = 1'b1; cfgWrData = d; instrDone = done;
    @(posedge clk);
    @(negedge clk);
    cfgWr = 1'b0; instrDone = 1'b0;
  endtask

  task automatic measure(input int maxC, output int n);
    n = 0;
    for (int i = 1; i <= maxC; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (timeoutEvt) begin
        n = i;
        return;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    int n;
    bit seen;

    // Reset state (R12, R9)
    @(negedge clk);
    chk(timeoutEvt == 0, "R9 evt low in reset", timeoutEvt, 0);
    chk(wdtFlag == 0 && stopFlag == 0, "R12 flags clear in reset", wdtFlag + stopFlag, 0);
    chk(vecAddr == 16'h0020, "R9 vector", vecAddr, 32);

    // Vector table: R1, R2, R7
    foreach (VECS[k]) begin
      pinReset();
      mode = VECS[k][3:2];
      writeCfg({VECS[k][6:4], VECS[k][1], 1'b0}, 1'b1);
      if (VECS[k][0]) begin
        measure(periodOf(int'(VECS[k][6:4])) + 16, n);
        chk(n == periodOf(int'(VECS[k][6:4])), "R1 R7 table period", n,
            periodOf(int'(VECS[k][6:4])));
      end else begin
        measure(300, n);
        chk(n == 0, "R2 R7 table no timeout", n, 0);
      end
    end

    // Default period after pin reset (R3), event pulse and flag (R9)
    pinReset();
    measure(2100, n);
    chk(n == periodOf(7), "R3 default period", n, periodOf(7));
    chk(wdtFlag == 1, "R9 flag set", wdtFlag, 1);
    @(posedge clk); @(negedge clk);
    chk(timeoutEvt == 0, "R9 one-cycle pulse", timeoutEvt, 0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(wdtFlag == 1, "R10 flag sticky", wdtFlag, 1);

    // Write on the instrDone cycle accepted, later write ignored (R4)
    pinReset();
    writeCfg({3'd1, 1'b1, 1'b0}, 1'b1);
    measure(40, n);
    chk(n == 32, "R4 write in window", n, 32);
    writeCfg({3'd3, 1'b1, 1'b0}, 1'b0);
    pulseRefresh();
    measure(80, n);
    chk(n == 32, "R4 late write ignored", n, 32);

    // Refresh restarts the period (R5)
    pulseRefresh();
    repeat (20) @(posedge clk);
    @(negedge clk);
    pulseRefresh();
    measure(60, n);
    chk(n == 32, "R5 refresh restarts", n, 32);

    // Collision: refresh and clear on the expiry edge (R6, R10)
    wdtFlagClr = 1'b1;
    @(posedge clk); @(negedge clk);
    wdtFlagClr = 1'b0;
    chk(wdtFlag == 0, "R10 clear works", wdtFlag, 0);
    repeat (30) @(posedge clk);
    @(negedge clk);
    refresh = 1'b1; wdtFlagClr = 1'b1;
    @(posedge clk); @(negedge clk);
    refresh = 1'b0; wdtFlagClr = 1'b0;
    chk(timeoutEvt == 1, "R6 expiry beats refresh", timeoutEvt, 1);
    chk(wdtFlag == 1, "R10 set beats clear", wdtFlag, 1);
    measure(60, n);
    chk(n == 32, "R6 next period from collision edge", n, 32);

    // Stop freezes the count (R8); halt with halt counting off (R7)
    pinReset();
    writeCfg({3'd1, 1'b0, 1'b1}, 1'b1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    mode = 2'b10;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); @(negedge clk);
      if (timeoutEvt) seen = 1;
    end
    chk(!seen, "R8 no timeout in stop", seen, 0);
    mode = 2'b00;
    measure(60, n);
    chk(n == 22, "R8 resumes after stop", n, 22);
    repeat (5) @(posedge clk);
    @(negedge clk);
    mode = 2'b01;
    repeat (60) @(posedge clk);
    @(negedge clk);
    mode = 2'b00;
    measure(60, n);
    chk(n == 27, "R7 halt freezes when disabled", n, 27);

    // Stop flag (R11) and soft reset keeps flags (R12)
    stopExec = 1'b1;
    @(posedge clk); @(negedge clk);
    stopExec = 1'b0;
    chk(stopFlag == 1, "R11 stop flag set", stopFlag, 1);
    softRst = 1'b1;
    @(posedge clk); @(negedge clk);
    softRst = 1'b0;
    chk(wdtFlag == 1 && stopFlag == 1, "R12 soft reset keeps flags",
        wdtFlag + stopFlag, 2);
    writeCfg({3'd1, 1'b1, 1'b0}, 1'b1);
    measure(40, n);
    chk(n == 32, "R12 soft reset reopens window", n, 32);
    stopFlagClr = 1'b1;
    @(posedge clk); @(negedge clk);
    stopFlagClr = 1'b0;
    chk(stopFlag == 0, "R11 stop flag clear", stopFlag, 0);
    stopExec = 1'b1;
    @(posedge clk); @(negedge clk);
    stopExec = 1'b0;
    chk(stopFlag == 0, "R11 stop ignored when disabled", stopFlag, 0);
    pinReset();
    @(negedge clk);
    chk(wdtFlag == 0, "R12 pin reset clears timeout flag", wdtFlag, 0);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule